// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Sequencer

This block drives the strobes for one chip-select region of an asynchronous static memory bus. It produces a chip select, a beat address, an output enable and a write enable, and it counts every interval in memory clock cycles. A configuration word for the region gives four things: a device-type code, a first-beat latency, a follow-on-beat latency and a bus-release gap. The configuration is captured when a request is accepted. For each beat the sequencer chooses the first-beat or the follow-on latency from the device type and from the beat's position in the burst.

A requester presents a base address, a read/write flag, a beat count and a memory-space identifier. It holds them until `req_ready` is high while `req_valid` is asserted. During a read the block marks each beat's data with a one-cycle `rd_valid`. A one-cycle `done` closes every transfer. After a transfer the block holds off any request to a different memory space for the configured release gap, so that the device has time to stop driving the data bus. A request to the same space may follow at once.

Top module: `asm_timing_seq`

## Requirements
- R1: After reset, `cs_n`, `oe_n` and `we_n` are high, `done`, `err` and `rd_valid` are low, and `req_ready` is high.
- R2: Type code 3'b000 (non-burst ROM) read: every beat lasts `cfg_first`+1 cycles, with `cs_n` and `oe_n` low throughout. `rd_valid` is high only on the last cycle of each beat. `mem_addr` equals `req_addr` plus the beat index. `req_len` carries the beat count minus one (0 to 7).
- R3: Type code 3'b011 (burst-of-8 ROM) read: beat 0 lasts `cfg_first`+1 cycles and each later beat lasts `cfg_next`+1 cycles.
- R4: Type code 3'b010 (burst-of-4 ROM) read: beats whose index is a multiple of 4 last `cfg_first`+1 cycles and all other beats last `cfg_next`+1 cycles.
- R5: Type code 3'b001 (SRAM) read: every beat lasts `cfg_first`+1 cycles, and `oe_n` stays low with no gap between beats.
- R6: SRAM write: every beat lasts `cfg_next`+2 cycles, with `we_n` low for the first `cfg_next`+1 cycles and high for the final cycle. `oe_n` stays high.
- R7: Write to a ROM-type region (codes 000, 010, 011): exactly one beat is performed whatever `req_len` is, and `we_n` is low for `cfg_first`+1 cycles.
- R8: `done` is high for exactly the one cycle after the last cycle of the final beat, and `cs_n`, `oe_n` and `we_n` are all high in that cycle.
- R9: In each of the `cfg_gap` cycles that follow the `done` cycle of a supported transfer, `req_ready` is low when `req_space` differs from that transfer's space and high when it matches. `req_ready` is low during a transfer and in its `done` cycle.
- R10: Type codes 3'b100 to 3'b111 are unsupported. Such a request gives `done` and `err` together in the cycle after acceptance, drives no strobe, and does not start a release gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_type | input | 3 | Device-type code of the region |
| cfg_first | input | 4 | First-beat latency count |
| cfg_next | input | 4 | Follow-on-beat latency count |
| cfg_gap | input | 4 | Bus-release gap in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 3 | Beat count minus one |
| req_space | input | 2 | Memory-space identifier of the request |
| req_addr | input | 16 | Base beat address |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| mem_addr | output | 16 | Current beat address |
| rd_valid | output | 1 | Read data valid on the last cycle of a beat |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Unsupported device type, valid with done |

## Verification
The bench compares every bus cycle of whole transfers against a latency model kept in the bench. It can therefore catch a burst-of-4 sequencer that fails to reload the first-beat latency at beat 4, and a burst-of-8 sequencer that reloads it where it should not. It drives ROM writes with long beat counts to expose a sequencer that bursts writes into ROM. It checks the single high write-enable cycle that ends each SRAM write beat, which would be missing if the design used the read timing. It counts the cycles in which a different space is held off after `done`, so a gap that is off by one in either direction shows up. It then sends an unsupported request with a large gap setting and checks that the request leaves no hold-off behind.

// File: rtl/asm_seq_pkg.sv
// Package: shared codes and state type for the static memory sequencer.
// Assumes a 3-bit device-type field; codes at or above 3'b100 are unsupported.
package asm_seq_pkg;
    localparam int TYPE_W = 3;
    typedef logic [TYPE_W-1:0] dev_t;

    localparam dev_t DEV_ROM    = 3'b000;
    localparam dev_t DEV_SRAM   = 3'b001;
    localparam dev_t DEV_BURST4 = 3'b010;
    localparam dev_t DEV_BURST8 = 3'b011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    // True for the device codes this sequencer can time.
    function automatic logic dev_supported(input dev_t t);
        return t[TYPE_W-1] == 1'b0;
    endfunction
endpackage

// File: rtl/asm_beat_timer.sv
// Beat timer: counts cycles inside each beat and beats inside a transfer.
// Picks each beat's length from device type, direction and beat index.
// Assumes its configuration inputs stay stable while active is high.
module asm_beat_timer
    import asm_seq_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  dev_t              dev_type,
    input  logic              is_write,
    input  logic [CNT_W-1:0]  first_lat,
    input  logic [CNT_W-1:0]  next_lat,
    input  logic [BEAT_W-1:0] last_idx,
    output logic [CNT_W:0]    cyc_cnt,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              beat_end,
    output logic              last_end
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] len_first;
    logic [LEN_W-1:0] len_next;
    logic [LEN_W-1:0] len_wr_sram;
    logic [LEN_W-1:0] beat_len;

    // Candidate beat lengths in cycles.
    always_comb begin
        len_first   = {1'b0, first_lat} + LEN_W'(1);
        len_next    = {1'b0, next_lat} + LEN_W'(1);
        len_wr_sram = {1'b0, next_lat} + LEN_W'(2);
    end

    // Select the length of the current beat.
    always_comb begin
        beat_len = len_first;
        if (is_write) begin
            beat_len = (dev_type == DEV_SRAM) ? len_wr_sram : len_first;
        end else begin
            case (dev_type)
                DEV_BURST4: beat_len = (beat_idx[1:0] == 2'b00) ? len_first : len_next;
                DEV_BURST8: beat_len = (beat_idx == '0) ? len_first : len_next;
                default:    beat_len = len_first;
            endcase
        end
    end

    // End-of-beat and end-of-transfer flags.
    always_comb begin
        beat_end = active && (cyc_cnt == beat_len - LEN_W'(1));
        last_end = beat_end && (beat_idx == last_idx);
    end

    // Cycle and beat counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_cnt  <= '0;
            beat_idx <= '0;
        end else if (start) begin
            cyc_cnt  <= '0;
            beat_idx <= '0;
        end else if (beat_end) begin
            cyc_cnt  <= '0;
            beat_idx <= beat_idx + BEAT_W'(1);
        end else if (active) begin
            cyc_cnt  <= cyc_cnt + LEN_W'(1);
        end
    end
endmodule

// File: rtl/asm_gap_guard.sv
// Gap guard: after a transfer, holds off requests to a different space
// for a programmed number of cycles. The same space is always allowed.
module asm_gap_guard #(
    parameter int CNT_W   = 4,
    parameter int SPACE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CNT_W-1:0]   gap_val,
    input  logic [SPACE_W-1:0] load_space,
    input  logic [SPACE_W-1:0] req_space,
    output logic               space_ok
);
    logic [CNT_W-1:0]   gap_cnt;
    logic [SPACE_W-1:0] last_space;

    // Load the gap at transfer end, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt    <= '0;
            last_space <= '0;
        end else if (load) begin
            gap_cnt    <= gap_val;
            last_space <= load_space;
        end else if (gap_cnt != '0) begin
            gap_cnt    <= gap_cnt - CNT_W'(1);
        end
    end

    // A request may go once the gap has expired or when it targets the same space.
    always_comb begin
        space_ok = (gap_cnt == '0) || (req_space == last_space);
    end
endmodule

// File: rtl/asm_timing_seq.sv
// Top: timing sequencer for one asynchronous static memory region.
// Accepts one request at a time, captures the configuration, drives
// cs_n/oe_n/we_n and the beat address, and enforces the release gap.
// Assumes req_* stay stable while req_valid is high and not yet accepted.
module asm_timing_seq
    import asm_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SPACE_W = 2,
    parameter int CNT_W   = 4,
    parameter int BEAT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_type,
    input  logic [CNT_W-1:0]   cfg_first,
    input  logic [CNT_W-1:0]   cfg_next,
    input  logic [CNT_W-1:0]   cfg_gap,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [BEAT_W-1:0]  req_len,
    input  logic [SPACE_W-1:0] req_space,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               cs_n,
    output logic               oe_n,
    output logic               we_n,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               rd_valid,
    output logic               done,
    output logic               err
);
    seq_state_t         state;
    dev_t               type_q;
    logic               write_q;
    logic               err_q;
    logic [CNT_W-1:0]   first_q;
    logic [CNT_W-1:0]   next_q;
    logic [CNT_W-1:0]   gap_q;
    logic [SPACE_W-1:0] space_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [BEAT_W-1:0]  last_q;

    logic               space_ok;
    logic               accept;
    logic               start;
    logic               active;
    logic [CNT_W:0]     cyc_cnt;
    logic [BEAT_W-1:0]  beat_idx;
    logic               beat_end;
    logic               last_end;
    logic               gap_load;

    // Handshake and control decode.
    always_comb begin
        req_ready = (state == ST_IDLE) && space_ok;
        accept    = req_valid && req_ready;
        start     = accept && dev_supported(cfg_type);
        active    = (state == ST_BEAT);
        gap_load  = (state == ST_FIN) && !err_q;
    end

    // Sequencer state and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            type_q  <= DEV_ROM;
            write_q <= 1'b0;
            err_q   <= 1'b0;
            first_q <= '0;
            next_q  <= '0;
            gap_q   <= '0;
            space_q <= '0;
            addr_q  <= '0;
            last_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        type_q  <= cfg_type;
                        write_q <= req_write;
                        first_q <= cfg_first;
                        next_q  <= cfg_next;
                        gap_q   <= cfg_gap;
                        space_q <= req_space;
                        addr_q  <= req_addr;
                        last_q  <= (req_write && cfg_type != DEV_SRAM) ? '0 : req_len;
                        err_q   <= !dev_supported(cfg_type);
                        state   <= dev_supported(cfg_type) ? ST_BEAT : ST_FIN;
                    end
                end
                ST_BEAT: begin
                    if (last_end) begin
                        state <= ST_FIN;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    asm_beat_timer #(
        .CNT_W  (CNT_W),
        .BEAT_W (BEAT_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .active    (active),
        .dev_type  (type_q),
        .is_write  (write_q),
        .first_lat (first_q),
        .next_lat  (next_q),
        .last_idx  (last_q),
        .cyc_cnt   (cyc_cnt),
        .beat_idx  (beat_idx),
        .beat_end  (beat_end),
        .last_end  (last_end)
    );

    asm_gap_guard #(
        .CNT_W   (CNT_W),
        .SPACE_W (SPACE_W)
    ) i_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (gap_load),
        .gap_val    (gap_q),
        .load_space (space_q),
        .req_space  (req_space),
        .space_ok   (space_ok)
    );

    // Bus strobes, beat address and completion outputs.
    always_comb begin
        cs_n     = !active;
        oe_n     = !(active && !write_q);
        we_n     = !(active && write_q &&
                     (type_q != DEV_SRAM || cyc_cnt <= {1'b0, next_q}));
        mem_addr = addr_q + ADDR_W'(beat_idx);
        rd_valid = active && !write_q && beat_end;
        done     = (state == ST_FIN);
        err      = (state == ST_FIN) && err_q;
    end
endmodule

// File: rtl/asm_seq_checker.sv
// Checker: port-level protocol properties of the sequencer, bound to the top.
module asm_seq_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_valid,
    input logic              done,
    input logic              err
);
    // R5: a strobe is only driven while the chip is selected.
    p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !cs_n);

    // R6: output enable and write enable are never low together.
    p_oe_we_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R2: read-data-valid only appears while output enable is low.
    p_rdv_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!oe_n && we_n));

    // R8: done lasts a single cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: strobes are released in the done cycle.
    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && oe_n && we_n));

    // R8: chip select rises only into a done cycle.
    p_cs_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    // R10: the error flag only comes with done.
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R9: no request is taken while a transfer or its done cycle is in progress.
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !done));
endmodule

bind asm_timing_seq asm_seq_checker #(
    .ADDR_W (ADDR_W)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .mem_addr  (mem_addr),
    .rd_valid  (rd_valid),
    .done      (done),
    .err       (err)
);

// File: tb/test_asm_timing_seq.sv
// Directed bench for the static memory timing sequencer.
module test_asm_timing_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_type = 3'd0;
    logic [3:0]  cfg_first = 4'd0;
    logic [3:0]  cfg_next = 4'd0;
    logic [3:0]  cfg_gap = 4'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_len = 3'd0;
    logic [1:0]  req_space = 2'd0;
    logic [15:0] req_addr = 16'd0;
    logic        cs_n, oe_n, we_n, rd_valid, done, err;
    logic [15:0] mem_addr;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    asm_timing_seq i_asm_timing_seq (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_first(cfg_first),
        .cfg_next(cfg_next), .cfg_gap(cfg_gap), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_len(req_len),
        .req_space(req_space), .req_addr(req_addr), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .mem_addr(mem_addr), .rd_valid(rd_valid), .done(done),
        .err(err)
    );

    // Expected beat length taken from the requirements.
    function automatic int exp_len(input int ty, input logic wr, input int b,
                                   input int f, input int n);
        if (wr) return (ty == 1) ? n + 2 : f + 1;
        case (ty)
            2:       return (b % 4 == 0) ? f + 1 : n + 1;
            3:       return (b == 0) ? f + 1 : n + 1;
            default: return f + 1;
        endcase
    endfunction

    // Issue one transfer and compare every bus cycle plus the done cycle.
    task automatic do_xfer(input int ty, input logic wr, input int f, input int n,
                           input int g, input int lenm1, input int sp, input int ad,
                           input string tag);
        int nb;
        int bad;
        int guard;
        logic exp_we;
        logic exp_rv;
        cfg_type  = 3'(ty);
        cfg_first = 4'(f);
        cfg_next  = 4'(n);
        cfg_gap   = 4'(g);
        req_write = wr;
        req_len   = 3'(lenm1);
        req_space = 2'(sp);
        req_addr  = 16'(ad);
        #1;
        guard = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nb  = (wr && ty != 1) ? 1 : lenm1 + 1;
        bad = 0;
        for (int b = 0; b < nb; b++) begin
            int len;
            len = exp_len(ty, wr, b, f, n);
            for (int c = 0; c < len; c++) begin
                exp_we = !(wr && (ty != 1 || c <= n));
                exp_rv = !wr && (c == len - 1);
                if (cs_n !== 1'b0 || oe_n !== wr || we_n !== exp_we ||
                    rd_valid !== exp_rv || mem_addr !== 16'(ad + b) || done !== 1'b0) begin
                    if (bad == 0)
                        $display("FAIL %s beat %0d cycle %0d: cs_n=%b oe_n=%b we_n=%b rdv=%b addr=%h done=%b expected cs_n=0 oe_n=%b we_n=%b rdv=%b addr=%h done=0",
                                 tag, b, c, cs_n, oe_n, we_n, rd_valid, mem_addr, done,
                                 wr, exp_we, exp_rv, 16'(ad + b));
                    bad++;
                end
                @(negedge clk);
            end
        end
        vectors++;
        if (bad != 0) miscompares++;
        vectors++;
        if (done !== 1'b1 || err !== 1'b0 || cs_n !== 1'b1 || oe_n !== 1'b1 || we_n !== 1'b1) begin
            miscompares++;
            $display("FAIL R8 (%s) end: done=%b err=%b cs_n=%b oe_n=%b we_n=%b expected 1 0 1 1 1",
                     tag, done, err, cs_n, oe_n, we_n);
        end
    endtask

    // Single scalar check helper.
    task automatic check_bit(input logic act, input logic expv, input string what);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s: actual=%b expected=%b", what, act, expv);
        end
    endtask

    // R1: idle outputs straight after reset.
    task automatic t_reset();
        @(negedge clk);
        vectors++;
        if (cs_n !== 1'b1 || oe_n !== 1'b1 || we_n !== 1'b1 || done !== 1'b0 ||
            err !== 1'b0 || rd_valid !== 1'b0 || req_ready !== 1'b1) begin
            miscompares++;
            $display("FAIL R1 reset: cs_n=%b oe_n=%b we_n=%b done=%b err=%b rdv=%b ready=%b expected 1 1 1 0 0 0 1",
                     cs_n, oe_n, we_n, done, err, rd_valid, req_ready);
        end
    endtask

    // R2: non-burst ROM reads.
    task automatic t_rom_read();
        do_xfer(0, 1'b0, 2, 9, 0, 2, 0, 16'h0100, "R2 rom 3 beats");
        do_xfer(0, 1'b0, 0, 5, 0, 0, 0, 16'hfffe, "R2 rom 1 beat");
    endtask

    // R3: burst-of-8 ROM read.
    task automatic t_burst8();
        do_xfer(3, 1'b0, 3, 1, 0, 7, 0, 16'h0200, "R3 burst8");
    endtask

    // R4: burst-of-4 ROM reads, restart at beat 4.
    task automatic t_burst4();
        do_xfer(2, 1'b0, 2, 0, 0, 7, 0, 16'h0300, "R4 burst4 8 beats");
        do_xfer(2, 1'b0, 4, 1, 0, 4, 0, 16'h0310, "R4 burst4 5 beats");
    endtask

    // R5: SRAM reads ignore the follow-on latency.
    task automatic t_sram_read();
        do_xfer(1, 1'b0, 1, 5, 0, 3, 0, 16'h0400, "R5 sram read");
    endtask

    // R6: SRAM writes with a high write-enable cycle per beat.
    task automatic t_sram_write();
        do_xfer(1, 1'b1, 7, 2, 0, 2, 0, 16'h0500, "R6 sram write");
        do_xfer(1, 1'b1, 3, 0, 0, 1, 0, 16'h0510, "R6 sram write n0");
    endtask

    // R7: ROM-type writes are single beat.
    task automatic t_rom_write();
        do_xfer(3, 1'b1, 2, 0, 0, 7, 0, 16'h0600, "R7 burst8 write");
        do_xfer(2, 1'b1, 1, 3, 0, 3, 0, 16'h0610, "R7 burst4 write");
        do_xfer(0, 1'b1, 0, 0, 0, 5, 0, 16'h0620, "R7 rom write");
    endtask

    // R9: release gap blocks a different space only.
    task automatic t_gap();
        do_xfer(1, 1'b0, 1, 1, 3, 0, 0, 16'h0700, "R9 gap xfer a");
        req_space = 2'd1;
        #1;
        check_bit(req_ready, 1'b0, "R9 ready in done cycle");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_bit(req_ready, 1'b0, "R9 other space inside gap");
        end
        @(negedge clk);
        check_bit(req_ready, 1'b1, "R9 other space after gap");
        do_xfer(0, 1'b0, 0, 0, 6, 0, 1, 16'h0710, "R9 gap xfer b");
        @(negedge clk);
        req_space = 2'd1;
        #1;
        check_bit(req_ready, 1'b1, "R9 same space inside gap");
        req_space = 2'd2;
        #1;
        check_bit(req_ready, 1'b0, "R9 other space inside gap b");
        repeat (10) @(negedge clk);
    endtask

    // R10: unsupported codes finish with an error and no strobes.
    task automatic t_err(input int ty);
        cfg_type  = 3'(ty);
        cfg_gap   = 4'd7;
        req_space = 2'd3;
        req_write = 1'b0;
        req_len   = 3'd3;
        #1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        vectors++;
        if (done !== 1'b1 || err !== 1'b1 || cs_n !== 1'b1 || oe_n !== 1'b1 ||
            we_n !== 1'b1 || rd_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R10 type %0d: done=%b err=%b cs_n=%b oe_n=%b we_n=%b rdv=%b expected 1 1 1 1 1 0",
                     ty, done, err, cs_n, oe_n, we_n, rd_valid);
        end
        @(negedge clk);
        req_space = 2'd2;
        #1;
        check_bit(req_ready, 1'b1, "R10 no gap after unsupported request");
        check_bit(done, 1'b0, "R10 done single cycle");
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rom_read();
        t_burst8();
        t_burst4();
        t_sram_read();
        t_sram_write();
        t_rom_write();
        t_gap();
        t_err(4);
        t_err(7);
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule